// File: doc/BRIEF.md
# SPI banked-register command monitor

This block is a passive observer for a byte-framed SPI link that drives a peripheral whose register file is split into four banks. A framer upstream turns the serial wires into a single tagged beat stream: chip-select falling, one beat per exchanged byte carrying the MOSI and MISO values together, and chip-select rising. When a frame closes with at least one byte in it, the monitor decodes the command class and the register address from the first byte. It then picks out the data byte that matters for that class, checks the frame length and header rules, and emits one report.

The peripheral selects its bank through two bits of a control register at address 0x1F. The monitor keeps its own copy of those bits by watching writes, bit-set and bit-clear operations aimed at that address, and reset commands. It keeps a separate "known" flag for each bit, so that a bit-set on only one bit leaves the bank undefined. Every report carries the bank in force before the frame was applied. Register-level checks are made against per-bank masks of unimplemented addresses and of addresses that need a dummy byte on read.

Both edges are valid/ready streams. The report side holds its fields stable until taken. While a report is pending and `rpt_ready` is low, `in_ready` is low and no beat is consumed, so the upstream framer must hold its beat. With `rpt_ready` high, the monitor accepts one beat per cycle.

Top module: `spi_cmd_monitor`

## Requirements
- R1: A report carries the opcode `rpt_cmd` (the first byte's bits 7:5: 0 register read, 1 buffer read, 2 register write, 3 buffer write, 4 bit set, 5 bit clear, 6 undefined, 7 reset) and the address `rpt_addr` (the first byte's bits 4:0). It also carries `rpt_payload`, which is the frame's byte count minus one.
- R2: While `rpt_valid` is high and `rpt_ready` is low, `in_ready` is low and every report field holds its value. A beat offered in that time is consumed in the cycle the report is taken.
- R3: A 2-byte register write to 0x1F loads both bank bits from bits 1:0 of byte 2, and marks both as known.
- R4: A 2-byte bit set or bit clear to 0x1F sets or clears each bank bit whose mask bit (byte 2 bit 0 or bit 1) is 1, and marks that bit known. `rpt_bank_known` is 1 only when both bits are known, and `rpt_bank` is 0 while it is 0. A bit operation to any other address leaves the bank alone.
- R5: A 1-byte reset command forces both bank bits to 0 and known. A reset frame of any other length raises warning bit 1 (length) and leaves the bank unchanged.
- R6: After reset, the bank is unknown. A register command of valid length then raises warning bit 2 (bank unknown) and skips the per-register checks.
- R7: A register read must be 2 or 3 bytes long, or warning bit 1 is raised and the data is 0. When the bank is known, a dummy-byte-class address must be read in 3 bytes and any other address in 2 bytes, or warning bit 5 (dummy misuse) is raised. The data is the MISO value of byte 3 for a 3-byte read and of byte 2 for a 2-byte read.
- R8: A register write, bit set or bit clear must be exactly 2 bytes long, or warning bit 1 is raised, the bank is not touched and no register check is made. The data is the MOSI value of byte 2.
- R9: A buffer read must start with 0x3A and a buffer write with 0x7A, or warning bit 4 (bad header) is raised. The data is the first payload byte, taken from MISO for a read and from MOSI for a write.
- R10: A register command of valid length to an unimplemented address of the known bank raises warning bit 3 (invalid register).
- R11: Opcode 6 raises warning bit 0 (undefined opcode) and nothing else.
- R12: A frame closed with no bytes produces no report. Byte and close beats outside a frame are ignored, beat kind 3 is ignored, and an open beat inside a frame restarts it. A report appears only in the cycle after a close beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat offered |
| in_ready | output | 1 | Beat accepted this cycle when high with in_valid |
| in_kind | input | 2 | 0 byte, 1 select open, 2 select close, 3 ignored |
| in_mosi | input | 8 | Controller-to-peripheral byte |
| in_miso | input | 8 | Peripheral-to-controller byte |
| rpt_valid | output | 1 | Report pending |
| rpt_ready | input | 1 | Report taken when high with rpt_valid |
| rpt_cmd | output | 3 | Opcode field |
| rpt_addr | output | 5 | Register address field |
| rpt_data | output | 8 | Data byte of interest |
| rpt_payload | output | CNT_W | Byte count minus one (saturating count) |
| rpt_bank_known | output | 1 | Both bank bits were known before the frame |
| rpt_bank | output | 2 | Bank in force before the frame |
| rpt_warn | output | 6 | Warning flags, bit positions as in the requirements |

## Verification
The bench goes after the bank snoop's memory across frames. It sets one bank bit at a time from the unknown state, and a design that tracked a single known flag would report a bank too early. It sends wrong-length writes and reset frames to 0x1F, and a design that applied them would show a moved bank on the next report. It reads dummy-class and plain addresses with both frame lengths, and a swapped MISO byte or class test would give the wrong data or a stray dummy flag. It also stalls the report side while offering a new beat, and restarts and empties frames: a monitor that ignored back-pressure would lose or change a report, and one that miscounted would shift the payload length.

// File: rtl/spimon_pkg.sv
package spimon_pkg;

  typedef enum logic [1:0] {
    BEAT_BYTE  = 2'd0,
    BEAT_OPEN  = 2'd1,
    BEAT_CLOSE = 2'd2,
    BEAT_IDLE  = 2'd3
  } beat_kind_e;

  typedef enum logic [2:0] {
    OP_RDREG = 3'd0,
    OP_RDBUF = 3'd1,
    OP_WRREG = 3'd2,
    OP_WRBUF = 3'd3,
    OP_BSET  = 3'd4,
    OP_BCLR  = 3'd5,
    OP_UNDEF = 3'd6,
    OP_RESET = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    BK_KEEP = 3'd0,
    BK_LOAD = 3'd1,
    BK_SET  = 3'd2,
    BK_CLR  = 3'd3,
    BK_ZERO = 3'd4
  } bank_op_e;

  localparam int WARN_W   = 6;
  localparam int W_OPCODE = 0;
  localparam int W_LENGTH = 1;
  localparam int W_NOBANK = 2;
  localparam int W_BADREG = 3;
  localparam int W_HEADER = 4;
  localparam int W_DUMMY  = 5;

  localparam int ADDR_W = 5;
  localparam int BANK_W = 2;
  localparam logic [ADDR_W-1:0] BANKCTL_ADDR = 5'h1F;
  localparam logic [7:0] RDBUF_HDR = 8'h3A;
  localparam logic [7:0] WRBUF_HDR = 8'h7A;

  // Addresses with no register behind them, one bit per address.
  function automatic logic [31:0] hole_mask(input logic [BANK_W-1:0] bank);
    case (bank)
      2'd0:    hole_mask = 32'h0700_0000;
      2'd1:    hole_mask = 32'h04CC_0000;
      2'd2:    hole_mask = 32'h042B_F022;
      default: hole_mask = 32'h0459_F800;
    endcase
  endfunction

  // Addresses whose read needs a dummy byte before the data.
  function automatic logic [31:0] slow_mask(input logic [BANK_W-1:0] bank);
    case (bank)
      2'd0:    slow_mask = 32'h0000_0000;
      2'd1:    slow_mask = 32'h0000_0000;
      2'd2:    slow_mask = 32'h03D4_0FDD;
      default: slow_mask = 32'h0000_043F;
    endcase
  endfunction

endpackage

// File: rtl/mon_frame_capture.sv
module mon_frame_capture
  import spimon_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_fire,
  input  logic [1:0]       beat_kind,
  input  logic [7:0]       beat_mosi,
  input  logic [7:0]       beat_miso,
  output logic             frame_done,
  output logic [CNT_W-1:0] count,
  output logic [7:0]       hdr,
  output logic [7:0]       mosi2,
  output logic [7:0]       miso2,
  output logic [7:0]       miso3
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic             take_byte;

  assign take_byte = beat_fire && (beat_kind == BEAT_BYTE) && active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      hdr      <= '0;
      mosi2    <= '0;
      miso2    <= '0;
      miso3    <= '0;
    end else if (beat_fire && beat_kind == BEAT_OPEN) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (beat_fire && beat_kind == BEAT_CLOSE) begin
      active_q <= 1'b0;
    end else if (take_byte) begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
      if (cnt_q == CNT_W'(0)) hdr <= beat_mosi;
      if (cnt_q == CNT_W'(1)) begin
        mosi2 <= beat_mosi;
        miso2 <= beat_miso;
      end
      if (cnt_q == CNT_W'(2)) miso3 <= beat_miso;
    end
  end

  assign frame_done = beat_fire && (beat_kind == BEAT_CLOSE) && active_q
                      && (cnt_q != '0);
  assign count = cnt_q;

  // R12: opening a frame discards any bytes counted before it
  p_open_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && beat_kind == BEAT_OPEN) |=> (count == '0));

  // R12: bytes outside a frame leave the count alone
  p_idle_bytes_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !(beat_fire && beat_kind == BEAT_OPEN)) |=> $stable(count));

endmodule

// File: rtl/mon_bank_tracker.sv
module mon_bank_tracker
  import spimon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              apply,
  input  bank_op_e          op,
  input  logic [BANK_W-1:0] bits,
  output logic [BANK_W-1:0] known,
  output logic [BANK_W-1:0] value
);
  logic [BANK_W-1:0] kn_q;
  logic [BANK_W-1:0] val_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kn_q  <= '0;
      val_q <= '0;
    end else if (apply) begin
      case (op)
        BK_LOAD: begin
          val_q <= bits;
          kn_q  <= '1;
        end
        BK_SET: begin
          val_q <= val_q | bits;
          kn_q  <= kn_q | bits;
        end
        BK_CLR: begin
          val_q <= val_q & ~bits;
          kn_q  <= kn_q | bits;
        end
        BK_ZERO: begin
          val_q <= '0;
          kn_q  <= '1;
        end
        default: ;
      endcase
    end
  end

  assign known = kn_q;
  assign value = val_q;

  // R4: a bank bit, once known, stays known until reset
  p_known0_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    kn_q[0] |=> kn_q[0]);
  p_known1_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    kn_q[1] |=> kn_q[1]);

  // R4: the bank only moves when a snooped operation is applied
  p_bank_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(val_q));

endmodule

// File: rtl/mon_cmd_classify.sv
module mon_cmd_classify
  import spimon_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic [7:0]        hdr,
  input  logic [CNT_W-1:0]  count,
  input  logic [7:0]        mosi2,
  input  logic [7:0]        miso2,
  input  logic [7:0]        miso3,
  input  logic [BANK_W-1:0] bank_known,
  input  logic [BANK_W-1:0] bank,
  output logic [WARN_W-1:0] warn,
  output logic [7:0]        data,
  output bank_op_e          bank_op
);
  op_e               op;
  logic [ADDR_W-1:0] addr;
  logic              all_known;
  logic [31:0]       holes;
  logic [31:0]       slow;
  logic              len1, len2, len3, has2;
  logic              reg_chk;

  assign op        = op_e'(hdr[7:5]);
  assign addr      = hdr[ADDR_W-1:0];
  assign all_known = &bank_known;
  assign holes     = hole_mask(bank);
  assign slow      = slow_mask(bank);
  assign len1      = (count == CNT_W'(1));
  assign len2      = (count == CNT_W'(2));
  assign len3      = (count == CNT_W'(3));
  assign has2      = (count > CNT_W'(1));

  always_comb begin
    warn    = '0;
    data    = '0;
    bank_op = BK_KEEP;
    reg_chk = 1'b0;
    case (op)
      OP_RDREG: begin
        if (len2 || len3) begin
          reg_chk = 1'b1;
          data    = len3 ? miso3 : miso2;
          if (all_known && (slow[addr] != len3)) warn[W_DUMMY] = 1'b1;
        end else begin
          warn[W_LENGTH] = 1'b1;
        end
      end
      OP_RDBUF: begin
        if (hdr != RDBUF_HDR) warn[W_HEADER] = 1'b1;
        if (has2) data = miso2;
      end
      OP_WRBUF: begin
        if (hdr != WRBUF_HDR) warn[W_HEADER] = 1'b1;
        if (has2) data = mosi2;
      end
      OP_WRREG, OP_BSET, OP_BCLR: begin
        if (has2) data = mosi2;
        if (len2) begin
          reg_chk = 1'b1;
          if (addr == BANKCTL_ADDR) begin
            if (op == OP_WRREG)     bank_op = BK_LOAD;
            else if (op == OP_BSET) bank_op = BK_SET;
            else                    bank_op = BK_CLR;
          end
        end else begin
          warn[W_LENGTH] = 1'b1;
        end
      end
      OP_RESET: begin
        if (len1) bank_op = BK_ZERO;
        else      warn[W_LENGTH] = 1'b1;
      end
      default: warn[W_OPCODE] = 1'b1;
    endcase
    if (reg_chk) begin
      if (!all_known)      warn[W_NOBANK] = 1'b1;
      else if (holes[addr]) warn[W_BADREG] = 1'b1;
    end
  end

endmodule

// File: rtl/spi_cmd_monitor.sv
module spi_cmd_monitor
  import spimon_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_kind,
  input  logic [7:0]        in_mosi,
  input  logic [7:0]        in_miso,
  output logic              rpt_valid,
  input  logic              rpt_ready,
  output logic [2:0]        rpt_cmd,
  output logic [ADDR_W-1:0] rpt_addr,
  output logic [7:0]        rpt_data,
  output logic [CNT_W-1:0]  rpt_payload,
  output logic              rpt_bank_known,
  output logic [BANK_W-1:0] rpt_bank,
  output logic [WARN_W-1:0] rpt_warn
);
  logic              beat_fire;
  logic              frame_done;
  logic [CNT_W-1:0]  cap_count;
  logic [7:0]        cap_hdr, cap_mosi2, cap_miso2, cap_miso3;
  logic [BANK_W-1:0] trk_known, trk_val, eff_bank;
  logic [WARN_W-1:0] cls_warn;
  logic [7:0]        cls_data;
  bank_op_e          cls_bank_op;

  assign in_ready  = !rpt_valid || rpt_ready;
  assign beat_fire = in_valid && in_ready;

  mon_frame_capture #(.CNT_W(CNT_W)) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_fire  (beat_fire),
    .beat_kind  (in_kind),
    .beat_mosi  (in_mosi),
    .beat_miso  (in_miso),
    .frame_done (frame_done),
    .count      (cap_count),
    .hdr        (cap_hdr),
    .mosi2      (cap_mosi2),
    .miso2      (cap_miso2),
    .miso3      (cap_miso3)
  );

  mon_bank_tracker u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .apply (frame_done),
    .op    (cls_bank_op),
    .bits  (cap_mosi2[BANK_W-1:0]),
    .known (trk_known),
    .value (trk_val)
  );

  assign eff_bank = (&trk_known) ? trk_val : '0;

  mon_cmd_classify #(.CNT_W(CNT_W)) u_classify (
    .hdr        (cap_hdr),
    .count      (cap_count),
    .mosi2      (cap_mosi2),
    .miso2      (cap_miso2),
    .miso3      (cap_miso3),
    .bank_known (trk_known),
    .bank       (eff_bank),
    .warn       (cls_warn),
    .data       (cls_data),
    .bank_op    (cls_bank_op)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rpt_valid      <= 1'b0;
      rpt_cmd        <= '0;
      rpt_addr       <= '0;
      rpt_data       <= '0;
      rpt_payload    <= '0;
      rpt_bank_known <= 1'b0;
      rpt_bank       <= '0;
      rpt_warn       <= '0;
    end else if (frame_done) begin
      rpt_valid      <= 1'b1;
      rpt_cmd        <= cap_hdr[7:5];
      rpt_addr       <= cap_hdr[ADDR_W-1:0];
      rpt_data       <= cls_data;
      rpt_payload    <= cap_count - CNT_W'(1);
      rpt_bank_known <= &trk_known;
      rpt_bank       <= eff_bank;
      rpt_warn       <= cls_warn;
    end else if (rpt_ready) begin
      rpt_valid      <= 1'b0;
    end
  end

  // R2: a stalled report keeps every field
  p_hold_report_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && !rpt_ready) |=> (rpt_valid && $stable({rpt_cmd, rpt_addr,
      rpt_data, rpt_payload, rpt_bank_known, rpt_bank, rpt_warn})));

  // R12: a report only follows an accepted close beat
  p_report_origin_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rpt_valid) |-> $past(in_valid && in_ready && in_kind == 2'd2));

  // R5: a one-byte reset frame leaves bank 0 defined
  p_reset_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && cap_hdr[7:5] == 3'd7 && cap_count == CNT_W'(1))
      |=> (trk_known == '1 && trk_val == '0));

  // R6: the bank-unknown warning only appears with an undefined bank
  p_nobank_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && rpt_warn[W_NOBANK]) |-> !rpt_bank_known);

  // R8: two-byte-only commands of any other length carry the length flag
  p_fixed_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && (rpt_cmd == 3'd2 || rpt_cmd == 3'd4 || rpt_cmd == 3'd5)
      && rpt_payload != CNT_W'(1)) |-> rpt_warn[W_LENGTH]);

endmodule

// File: tb/test_spi_cmd_monitor.sv
module test_spi_cmd_monitor;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid;
  logic             in_ready;
  logic [1:0]       in_kind;
  logic [7:0]       in_mosi, in_miso;
  logic             rpt_valid;
  logic             rpt_ready;
  logic [2:0]       rpt_cmd;
  logic [4:0]       rpt_addr;
  logic [7:0]       rpt_data;
  logic [CNT_W-1:0] rpt_payload;
  logic             rpt_bank_known;
  logic [1:0]       rpt_bank;
  logic [5:0]       rpt_warn;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  spi_cmd_monitor #(.CNT_W(CNT_W)) i_spi_cmd_monitor (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_ready       (in_ready),
    .in_kind        (in_kind),
    .in_mosi        (in_mosi),
    .in_miso        (in_miso),
    .rpt_valid      (rpt_valid),
    .rpt_ready      (rpt_ready),
    .rpt_cmd        (rpt_cmd),
    .rpt_addr       (rpt_addr),
    .rpt_data       (rpt_data),
    .rpt_payload    (rpt_payload),
    .rpt_bank_known (rpt_bank_known),
    .rpt_bank       (rpt_bank),
    .rpt_warn       (rpt_warn)
  );

  typedef struct packed {
    logic [3:0] n;
    logic [7:0] b0, b1, b2;
    logic [7:0] s1, s2;
    logic [2:0] cmd;
    logic [4:0] addr;
    logic [7:0] data;
    logic [7:0] pay;
    logic       kn;
    logic [1:0] bank;
    logic [5:0] warn;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 26;
  // Warning bits: 0 opcode, 1 length, 2 bank unknown, 3 bad register, 4 header, 5 dummy
  localparam vec_t VECS [NV] = '{
    '{2, 8'h05, 8'h00, 8'h00, 8'hA5, 8'h00, 0, 5'h05, 8'hA5, 1, 0, 0, 6'h04, 6},  // R6
    '{2, 8'h9F, 8'h01, 8'h00, 8'h00, 8'h00, 4, 5'h1F, 8'h01, 1, 0, 0, 6'h04, 4},  // R4 half known
    '{2, 8'h43, 8'h55, 8'h00, 8'h00, 8'h00, 2, 5'h03, 8'h55, 1, 0, 0, 6'h04, 6},  // R6
    '{2, 8'h9F, 8'h02, 8'h00, 8'h00, 8'h00, 4, 5'h1F, 8'h02, 1, 0, 0, 6'h04, 4},  // R4
    '{2, 8'h12, 8'h00, 8'h00, 8'h06, 8'h00, 0, 5'h12, 8'h06, 1, 1, 3, 6'h00, 4},  // R4 bank 3
    '{2, 8'h0A, 8'h00, 8'h00, 8'h11, 8'h00, 0, 5'h0A, 8'h11, 1, 1, 3, 6'h20, 7},  // R7 missing dummy
    '{3, 8'h0A, 8'h00, 8'h00, 8'hFF, 8'h42, 0, 5'h0A, 8'h42, 2, 1, 3, 6'h00, 7},  // R7
    '{2, 8'h4B, 8'h99, 8'h00, 8'h00, 8'h00, 2, 5'h0B, 8'h99, 1, 1, 3, 6'h08, 10}, // R10
    '{2, 8'hBF, 8'h01, 8'h00, 8'h00, 8'h00, 5, 5'h1F, 8'h01, 1, 1, 3, 6'h00, 4},  // R4 clear bit 0
    '{3, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h0D, 0, 5'h00, 8'h0D, 2, 1, 2, 6'h00, 7},  // R7 bank 2
    '{2, 8'h01, 8'h00, 8'h00, 8'h77, 8'h00, 0, 5'h01, 8'h77, 1, 1, 2, 6'h08, 10}, // R10
    '{3, 8'h05, 8'h00, 8'h00, 8'h00, 8'h33, 0, 5'h05, 8'h33, 2, 1, 2, 6'h28, 7},  // R7 extra dummy
    '{3, 8'h5F, 8'h00, 8'h03, 8'h00, 8'h00, 2, 5'h1F, 8'h00, 2, 1, 2, 6'h02, 8},  // R8 no load
    '{1, 8'hC4, 8'h00, 8'h00, 8'h00, 8'h00, 6, 5'h04, 8'h00, 0, 1, 2, 6'h01, 11}, // R11
    '{2, 8'h3A, 8'h00, 8'h00, 8'hBE, 8'h00, 1, 5'h1A, 8'hBE, 1, 1, 2, 6'h00, 9},  // R9
    '{1, 8'h3B, 8'h00, 8'h00, 8'h00, 8'h00, 1, 5'h1B, 8'h00, 0, 1, 2, 6'h10, 9},  // R9 bad header
    '{3, 8'h7A, 8'hC3, 8'h00, 8'h00, 8'h00, 3, 5'h1A, 8'hC3, 2, 1, 2, 6'h00, 9},  // R9
    '{2, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 7, 5'h1F, 8'h00, 1, 1, 2, 6'h02, 5},  // R5 long reset
    '{1, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 7, 5'h1F, 8'h00, 0, 1, 2, 6'h00, 5},  // R5
    '{2, 8'h5F, 8'h03, 8'h00, 8'h00, 8'h00, 2, 5'h1F, 8'h03, 1, 1, 0, 6'h00, 3},  // R3 bank was 0
    '{2, 8'h1A, 8'h00, 8'h00, 8'h00, 8'h00, 0, 5'h1A, 8'h00, 1, 1, 3, 6'h08, 3},  // R3 now 3
    '{2, 8'hBF, 8'h03, 8'h00, 8'h00, 8'h00, 5, 5'h1F, 8'h03, 1, 1, 3, 6'h00, 4},  // R4
    '{2, 8'h18, 8'h00, 8'h00, 8'h01, 8'h00, 0, 5'h18, 8'h01, 1, 1, 0, 6'h08, 10}, // R10 bank 0
    '{1, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00, 0, 5'h03, 8'h00, 0, 1, 0, 6'h02, 7},  // R7 short
    '{2, 8'h85, 8'h03, 8'h00, 8'h00, 8'h00, 4, 5'h05, 8'h03, 1, 1, 0, 6'h00, 4},  // R4 other addr
    '{2, 8'h1F, 8'h00, 8'h00, 8'h5A, 8'h00, 0, 5'h1F, 8'h5A, 1, 1, 0, 6'h00, 4}   // R4 bank kept
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic beat(input logic [1:0] kind, input logic [7:0] mo, input logic [7:0] mi);
    logic rdy;
    in_valid = 1'b1;
    in_kind  = kind;
    in_mosi  = mo;
    in_miso  = mi;
    forever begin
      rdy = in_ready;
      @(posedge clk);
      if (rdy) break;
      @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic frame(input int n, input logic [7:0] b0, b1, b2, s1, s2);
    beat(2'd1, 8'h00, 8'h00);
    if (n > 0) beat(2'd0, b0, 8'h00);
    if (n > 1) beat(2'd0, b1, s1);
    if (n > 2) beat(2'd0, b2, s2);
    beat(2'd2, 8'h00, 8'h00);
  endtask

  logic [2:0]       g_cmd;
  logic [4:0]       g_addr;
  logic [7:0]       g_data;
  logic [CNT_W-1:0] g_pay;
  logic             g_kn;
  logic [1:0]       g_bank;
  logic [5:0]       g_warn;

  task automatic take(input string tag);
    int waited = 0;
    while (!rpt_valid && waited < 20) begin
      @(negedge clk);
      waited++;
    end
    chk({tag, " report present"}, int'(rpt_valid), 1);
    g_cmd  = rpt_cmd;
    g_addr = rpt_addr;
    g_data = rpt_data;
    g_pay  = rpt_payload;
    g_kn   = rpt_bank_known;
    g_bank = rpt_bank;
    g_warn = rpt_warn;
    rpt_ready = 1'b1;
    @(negedge clk);
    rpt_ready = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_kind = 2'd3;
    in_mosi = '0;
    in_miso = '0;
    rpt_ready = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2 reset in_ready", int'(in_ready), 1);
    chk("R12 reset rpt_valid", int'(rpt_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string t;
      v = VECS[i];
      t = $sformatf("R%0d vec%0d", v.req, i);
      frame(int'(v.n), v.b0, v.b1, v.b2, v.s1, v.s2);
      take(t);
      chk($sformatf("R1 vec%0d cmd", i), int'(g_cmd), int'(v.cmd));
      chk($sformatf("R1 vec%0d addr", i), int'(g_addr), int'(v.addr));
      chk($sformatf("R1 vec%0d payload", i), int'(g_pay), int'(v.pay));
      chk({t, " data"}, int'(g_data), int'(v.data));
      chk({t, " known"}, int'(g_kn), int'(v.kn));
      chk({t, " bank"}, int'(g_bank), int'(v.bank));
      chk({t, " warn"}, int'(g_warn), int'(v.warn));
    end

    // R2: stall the report while a new beat is offered
    frame(2, 8'h00, 8'h00, 8'h00, 8'h66, 8'h00);
    @(negedge clk);
    in_valid = 1'b1;
    in_kind = 2'd1;
    chk("R2 stalled in_ready", int'(in_ready), 0);
    repeat (3) @(negedge clk);
    chk("R2 held valid", int'(rpt_valid), 1);
    chk("R2 held data", int'(rpt_data), 8'h66);
    rpt_ready = 1'b1;
    @(negedge clk);
    rpt_ready = 1'b0;
    in_valid = 1'b0;
    chk("R2 report taken", int'(rpt_valid), 0);
    beat(2'd0, 8'hFF, 8'h00);
    beat(2'd2, 8'h00, 8'h00);
    take("R2 beat kept");
    chk("R2 beat kept cmd", int'(g_cmd), 7);
    chk("R2 beat kept payload", int'(g_pay), 0);

    // R12: empty frames, stray beats, restart
    beat(2'd1, 8'h00, 8'h00);
    beat(2'd2, 8'h00, 8'h00);
    beat(2'd2, 8'h00, 8'h00);
    beat(2'd0, 8'h41, 8'h00);
    beat(2'd3, 8'h41, 8'h00);
    repeat (3) @(negedge clk);
    chk("R12 no report for empty or stray", int'(rpt_valid), 0);
    beat(2'd1, 8'h00, 8'h00);
    beat(2'd0, 8'h1F, 8'h00);
    beat(2'd3, 8'h99, 8'h00);
    beat(2'd0, 8'h00, 8'h5A);
    beat(2'd2, 8'h00, 8'h00);
    take("R12 stray excluded");
    chk("R12 stray excluded payload", int'(g_pay), 1);
    chk("R12 stray excluded data", int'(g_data), 8'h5A);
    beat(2'd1, 8'h00, 8'h00);
    beat(2'd0, 8'h41, 8'h00);
    beat(2'd1, 8'h00, 8'h00);
    beat(2'd0, 8'hFF, 8'h00);
    beat(2'd2, 8'h00, 8'h00);
    take("R12 restart");
    chk("R12 restart cmd", int'(g_cmd), 7);
    chk("R12 restart warn", int'(g_warn), 0);

    // R9: long buffer write
    beat(2'd1, 8'h00, 8'h00);
    beat(2'd0, 8'h7A, 8'h00);
    beat(2'd0, 8'hC3, 8'h00);
    beat(2'd0, 8'h11, 8'h00);
    beat(2'd0, 8'h22, 8'h00);
    beat(2'd0, 8'h33, 8'h00);
    beat(2'd2, 8'h00, 8'h00);
    take("R9 long write");
    chk("R9 long payload", int'(g_pay), 4);
    chk("R9 long data", int'(g_data), 8'hC3);
    chk("R9 long warn", int'(g_warn), 0);

    // R6: reset forgets the bank
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 reset rpt_valid", int'(rpt_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    frame(2, 8'h00, 8'h00, 8'h00, 8'h12, 8'h00);
    take("R6 after reset");
    chk("R6 after reset known", int'(g_kn), 0);
    chk("R6 after reset warn", int'(g_warn), 6'h04);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule